// File: doc/BRIEF.md
# Concurrent Write Resolution Unit

This block stands in front of one shared memory word and settles, in a single cycle, what happens when several processors try to write that word at once. Every processor port carries a request flag and a data word. A two-bit rule select chooses how a conflict is settled. The four rules are: agreement-only, pseudo-random pick, fixed-order pick, and additive merge. The block drives one write strobe and one write word toward the memory. It also raises a refusal flag when the agreement rule rejects a write.

The result is registered, so the memory sees the strobe and the word one clock after the requests. The rule select may change from one cycle to the next, and each cycle is resolved under the rule present in that cycle. The pseudo-random pick comes from a free-running shift-register sequence. That sequence sets the port at which a circular scan for the first requester begins.

Top module: `cw_resolver`

## Requirements
- R1: The rule select encodes 0 = agreement-only, 1 = pseudo-random pick, 2 = fixed-order pick and 3 = additive merge. Requests and rule presented before a rising edge set `wrEn`, `wrData` and `refused` right after that edge. During reset, `wrEn` and `refused` are low.
- R2: A cycle with no request flag set gives `wrEn` low and `refused` low in the next cycle, whatever the rule.
- R3: When exactly one port requests, every rule writes that port's data word unchanged.
- R4: Under the agreement-only rule, when all requesting ports present the same word, that word is written.
- R5: Under the agreement-only rule, when two requesting ports present different words, no write takes place and `refused` is high for that one result cycle only.
- R6: Under the pseudo-random pick, the written word equals the data word of one of the requesting ports.
- R7: Under the pseudo-random pick with every port requesting, the winning port is not fixed: over a run of cycles more than one port wins.
- R8: Under the fixed-order pick, the requesting port with the lowest index wins. Port 0 takes bits [W-1:0] of `reqData`, and port i takes bits [i*W +: W].
- R9: Under the additive merge, the written word is the sum of all requesting ports' words, taken modulo 2^W. A carry out of the word is dropped, and `refused` stays low.
- R10: `refused` is never high after a cycle that was resolved under a rule other than agreement-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Conflict rule select (encoding in R1) |
| reqValid | input | NUM_PORTS | One write request flag per processor port |
| reqData | input | NUM_PORTS*DATA_W | Packed data words, port i at bits [i*DATA_W +: DATA_W] |
| wrEn | output | 1 | Registered write strobe toward the memory word |
| wrData | output | DATA_W | Registered word to be written |
| refused | output | 1 | Registered flag: agreement-only rule rejected this write |

## Verification
A wrong pick shows up one cycle after the requests, either in the written word or in the write strobe. A selection that jumps to the wrong port writes a neighbour's word. A bad compare writes under disagreement or refuses under agreement. A sum that fails to mask absent ports changes the merged word. A corrupt start index shows only statistically, so the pseudo-random rule is checked two ways: each cycle for membership among the requesters, and over a long run for more than one winner. The refusal flag is checked in the cycle after a disagreement and again in the idle cycle that follows, so a flag that sticks is caught within one cycle.

// File: rtl/cw_resolver_pkg.sv
package cw_resolver_pkg;

  localparam int CW_LFSR_W = 8;

  typedef enum logic [1:0] {
    CW_AGREE  = 2'd0,
    CW_RANDOM = 2'd1,
    CW_ORDER  = 2'd2,
    CW_MERGE  = 2'd3
  } cw_rule_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic                 selAgree;
    logic                 selRandom;
    logic                 selOrder;
    logic                 selMerge;
    logic [CW_LFSR_W-1:0] scanStart;
  } cw_strobe_t;

endpackage

// File: rtl/cw_resolver_ctrl.sv
module cw_resolver_ctrl
  import cw_resolver_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  output cw_strobe_t strb
);

  localparam logic [CW_LFSR_W-1:0] SEED = CW_LFSR_W'(1);

  logic [CW_LFSR_W-1:0] lfsrQ;
  logic                 feedback;
  cw_rule_e             rule;

  // Maximal-length 8-bit sequence x^8 + x^6 + x^5 + x^4 + 1
  assign feedback = lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsrQ <= SEED;
    else        lfsrQ <= {lfsrQ[CW_LFSR_W-2:0], feedback};
  end

  assign rule = cw_rule_e'(mode);

  always_comb begin
    strb.selAgree  = (rule == CW_AGREE);
    strb.selRandom = (rule == CW_RANDOM);
    strb.selOrder  = (rule == CW_ORDER);
    strb.selMerge  = (rule == CW_MERGE);
    strb.scanStart = CW_LFSR_W'(int'(lfsrQ) % NUM_PORTS);
  end

  // The sequence register must never lock at zero
  a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    lfsrQ != '0);

endmodule

// File: rtl/cw_resolver_dp.sv
module cw_resolver_dp
  import cw_resolver_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  cw_strobe_t                    strb,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [NUM_PORTS*DATA_W-1:0]   reqData,
  output logic                          wrEn,
  output logic [DATA_W-1:0]             wrData,
  output logic                          refused
);

  logic [DATA_W-1:0] lane [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
    assign lane[g] = reqData[g*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] orderData, sumData, randData, nxtData;
  logic              mismatch, randFound, anyValid, nxtEn, nxtRef;
  int                scanIdx;

  always_comb begin
    // lowest index requester
    orderData = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--)
      if (reqValid[i]) orderData = lane[i];

    // modulo-2^W accumulation of requesters only
    sumData = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (reqValid[i]) sumData = sumData + lane[i];

    // any requester disagreeing with the lowest one
    mismatch = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (reqValid[i] && (lane[i] != orderData)) mismatch = 1'b1;

    // circular scan from the pseudo-random start port
    randData  = '0;
    randFound = 1'b0;
    scanIdx   = 0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      scanIdx = (int'(strb.scanStart) + k) % NUM_PORTS;
      if (!randFound && reqValid[scanIdx]) begin
        randData  = lane[scanIdx];
        randFound = 1'b1;
      end
    end

    anyValid = |reqValid;
    nxtRef   = anyValid && strb.selAgree && mismatch;
    nxtEn    = anyValid && !(strb.selAgree && mismatch);
    if (strb.selMerge)       nxtData = sumData;
    else if (strb.selRandom) nxtData = randData;
    else                     nxtData = orderData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn    <= 1'b0;
      wrData  <= '0;
      refused <= 1'b0;
    end else begin
      wrEn    <= nxtEn;
      wrData  <= nxtData;
      refused <= nxtRef;
    end
  end

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid == '0) |=> (!wrEn && !refused));

  a_r3_single_writes: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(reqValid) == 1) |=> wrEn);

  a_r5_refuse_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> !wrEn);

  a_r8_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.selOrder && reqValid[0]) |=> (wrData == $past(lane[0])));

  a_r9_merge_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.selMerge && (reqValid != '0)) |=> (wrEn && !refused));

  a_r10_refuse_agree_only: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> $past(strb.selAgree));

endmodule

// File: rtl/cw_resolver.sv
module cw_resolver
  import cw_resolver_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  mode,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*DATA_W-1:0] reqData,
  output logic                        wrEn,
  output logic [DATA_W-1:0]           wrData,
  output logic                        refused
);

  cw_strobe_t strb;

  cw_resolver_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .strb  (strb)
  );

  cw_resolver_dp #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .reqValid (reqValid),
    .reqData  (reqData),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .refused  (refused)
  );

endmodule

// File: tb/cw_resolver_bench.sv
`timescale 1ns/1ps
module cw_resolver_bench;

  localparam int P = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     mode;
  logic [P-1:0]   reqValid;
  logic [P*W-1:0] reqData;
  logic           wrEn;
  logic [W-1:0]   wrData;
  logic           refused;

  always #2 clk = ~clk;

  cw_resolver #(.NUM_PORTS(P), .DATA_W(W)) u_cw_resolver (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reqValid(reqValid),
    .reqData(reqData), .wrEn(wrEn), .wrData(wrData), .refused(refused)
  );

  typedef struct {
    logic           en;
    logic           rf;
    logic [W-1:0]   dat;
    bit             anyOf;
    logic [P-1:0]   v;
    logic [P*W-1:0] d;
    bit             track;
    string          tag;
  } exp_t;

  exp_t         sbq[$];
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 0;
  logic [P-1:0] seenMask = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one request cycle and queues what should follow it
  task automatic drive(input logic [1:0] m, input logic [P-1:0] v,
                       input logic [P*W-1:0] d, input string tag, input bit track = 0);
    exp_t e;
    int   cnt;
    logic [W-1:0] first, s;
    bit   same;
    @(negedge clk);
    mode = m; reqValid = v; reqData = d;
    cnt = $countones(v);
    first = '0; s = '0; same = 1;
    for (int i = P - 1; i >= 0; i--) if (v[i]) first = d[i*W +: W];
    for (int i = 0; i < P; i++) if (v[i]) begin
      s = s + d[i*W +: W];
      if (d[i*W +: W] != first) same = 0;
    end
    e.en = 0; e.rf = 0; e.dat = '0; e.anyOf = 0;
    e.v = v; e.d = d; e.track = track; e.tag = tag;
    if (cnt == 1) begin
      e.en = 1; e.dat = first;
    end else if (cnt > 1) begin
      case (m)
        2'd0: if (same) begin e.en = 1; e.dat = first; end else e.rf = 1;
        2'd1: begin e.en = 1; e.anyOf = 1; end
        2'd2: begin e.en = 1; e.dat = first; end
        default: begin e.en = 1; e.dat = s; end
      endcase
    end
    sbq.push_back(e);
  endtask

  // Monitor: compares each result cycle against the queued expectation
  initial begin
    exp_t e;
    bit   hit;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(wrEn == e.en, {e.tag, " wrEn"}, 32'(wrEn), 32'(e.en));
        check(refused == e.rf, {e.tag, " refused"}, 32'(refused), 32'(e.rf));
        if (e.en && e.anyOf) begin
          hit = 0;
          for (int i = 0; i < P; i++)
            if (e.v[i] && wrData == e.d[i*W +: W]) begin
              hit = 1;
              if (e.track) seenMask[i] = 1'b1;
            end
          check(hit, {e.tag, " winner is a requester"}, 32'(wrData), 32'(e.d));
        end else if (e.en) begin
          check(wrData == e.dat, {e.tag, " wrData"}, 32'(wrData), 32'(e.dat));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; reqValid = '0; reqData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(wrEn == 1'b0, "R1 reset wrEn", 32'(wrEn), 0);
    check(refused == 1'b0, "R1 reset refused", 32'(refused), 0);
    rst_n = 1'b1;

    // R2 idle under every rule, with junk data on the bus
    for (int m = 0; m < 4; m++) drive(2'(m), 4'b0000, 32'hDEADBEEF, "R2");

    // R3 single requester under every rule
    for (int m = 0; m < 4; m++) drive(2'(m), 4'b0100, 32'h11223344, "R3");
    for (int m = 0; m < 4; m++) drive(2'(m), 4'b1000, 32'hFE000000, "R3");

    // R4 agreement
    drive(2'd0, 4'b1011, 32'h5A775A5A, "R4");
    drive(2'd0, 4'b1111, 32'h00000000, "R4");
    // R5 disagreement, then idle to see the flag drop
    drive(2'd0, 4'b0011, 32'h00000102, "R5");
    drive(2'd0, 4'b0000, 32'h00000102, "R5");
    drive(2'd0, 4'b1001, 32'h80000081, "R5");

    // R8 fixed order
    drive(2'd2, 4'b1100, 32'hAABB0000, "R8");
    drive(2'd2, 4'b1111, 32'h44332211, "R8");
    drive(2'd2, 4'b0110, 32'h00CCDD00, "R8");

    // R9 additive merge with wrap
    drive(2'd3, 4'b1111, 32'hF0200102, "R9");
    drive(2'd3, 4'b0101, 32'h00FF0001, "R9");
    drive(2'd3, 4'b1010, 32'h80008000, "R9");

    // R6 and R7 pseudo-random pick
    for (int n = 0; n < 24; n++) drive(2'd1, 4'b1111, 32'hD4C3B2A1, "R6", 1);
    drive(2'd1, 4'b0101, 32'h00110022, "R6");
    drive(2'd1, 4'b1010, 32'h33004400, "R6");

    // R1 and R10 back-to-back rule changes
    drive(2'd0, 4'b0011, 32'h00000709, "R10");
    drive(2'd3, 4'b0011, 32'h00000709, "R10");
    drive(2'd2, 4'b0011, 32'h00000709, "R1");
    drive(2'd1, 4'b0011, 32'h00000707, "R1");
    drive(2'd0, 4'b0011, 32'h00000707, "R1");

    @(negedge clk);
    mode = 2'd0; reqValid = '0;
    repeat (3) @(posedge clk);
    #1;
    check($countones(seenMask) >= 2, "R7 distinct winners", 32'($countones(seenMask)), 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule